// File: doc/BRIEF.md
# Video blanking window generator

This block decides, pixel by pixel, whether an interlaced video encoder should treat the current input sample as picture content or as blanking. It follows the incoming horizontal and vertical sync pulses with two counters: a pixel counter that restarts on every horizontal sync leading edge, and a line counter that restarts on the vertical sync leading edge of an odd field and runs on through the even field. A horizontal window and a vertical window are compared against these counters. Their union drives a blanking output and its complement, a pixel-accept strobe.

Software sets the window edges through a byte-wide write port. The horizontal start and end values are measured from different origins relative to the sync edge. The vertical start and end are programmed once, for the odd field. For the even field they are moved down automatically by 262 lines for 525-line timing or 313 lines for 625-line timing. New values go into shadow registers and reach the comparators only at the next vertical sync leading edge, so a field is never blanked with a mix of old and new edges. When the blanking output function is disabled, the output stays inactive and every pixel is accepted.

Top module: `vbw_blank_gen`

## Requirements
- R1: While reset is held, and after it is released, `blank_o` is 0 and `pix_accept_o` is 1. The active configuration is then: horizontal start 0x37A, horizontal end 0x80, vertical start line 256 and vertical end line 20.
- R2: Define pixel count 0 as the cycle that follows the clock edge at which `hsync_i` is first sampled high. The count then rises by one each cycle. Blanking turns on at the 10-bit horizontal start value S measured with the sync edge as position 0x20. `blank_o` is therefore first high at count S − 0x20 + 1 and is low at count S − 0x20.
- R3: Blanking turns off at the 8-bit horizontal end value E measured with the sync edge as position 0. `blank_o` is still high at count E and low at count E + 1. A window that started late in one line stays active across the next sync edge.
- R4: Configuration write addresses (`cfg_addr_i`): 0 sets horizontal start bits 7:0; 1 sets horizontal start bits 9:8 from data bits 1:0; 2 sets horizontal end; 3 sets vertical start bits 7:0; 4 sets vertical start bit 8 from data bit 0; 5 sets vertical end bits 7:0; 6 sets vertical end bit 8 from data bit 0.
- R5: The line counter becomes 0 when `vsync_i` rises while `field_odd_i` is 1, and rises by one on every `hsync_i` leading edge. In an odd field, vertical blanking covers lines V through Ve − 1, where V is the vertical start and Ve the vertical end. It is visible from pixel count 1 of line V onward.
- R6: In an even field with `pal_mode_i` = 0, latched at that field's vertical sync edge, the vertical window covers lines V + 262 through Ve + 261.
- R7: In an even field with `pal_mode_i` = 1, latched at that field's vertical sync edge, the vertical window covers lines V + 313 through Ve + 312.
- R8: Configuration writes have no effect on blanking until the next `vsync_i` leading edge. From that edge on they apply.
- R9: While `blank_out_en_i` is 0, `blank_o` stays 0 and `pix_accept_o` stays 1, whatever the windows hold.
- R10: `pix_accept_o` is always the inverse of `blank_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| hsync_i | input | 1 | Horizontal sync pulse, leading edge is the rising edge |
| vsync_i | input | 1 | Vertical sync pulse, leading edge is the rising edge |
| field_odd_i | input | 1 | 1 during an odd field, sampled at the vertical sync edge |
| pal_mode_i | input | 1 | 1 selects 625-line field offset, sampled at the vertical sync edge |
| blank_out_en_i | input | 1 | Enables the blanking output function |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 8 | Configuration write data |
| blank_o | output | 1 | Blanking active |
| pix_accept_o | output | 1 | Input pixel is taken as picture data |

## Verification
Every window edge appears at the outputs one clock after the counter holds the matching value. A horizontal edge at start value S therefore shows at pixel count S − 0x20 + 1, and an end at E first clears at count E + 1. A vertical edge shows at pixel count 1 of its line, because the line counter itself moves on the sync-sampling edge. The bench logs both outputs at every falling clock edge of a line, tagged with the pixel count that the preceding rising edge produced, and compares the log entries at the counts just before and just after each edge. New configuration is checked once inside the same field, where the old window must still apply, and again after the next vertical sync leading edge.

// File: rtl/vbw_pkg.sv
package vbw_pkg;

   // Configuration register select codes
   typedef enum logic [2:0] {
      REG_HS_LO = 3'd0,
      REG_HS_HI = 3'd1,
      REG_HE    = 3'd2,
      REG_VS_LO = 3'd3,
      REG_VS_HI = 3'd4,
      REG_VE_LO = 3'd5,
      REG_VE_HI = 3'd6
   } vbw_reg_e;

   localparam int unsigned VBW_ADDR_W = $bits(vbw_reg_e);

endpackage

// File: rtl/vbw_field_reg.sv
module vbw_field_reg #(
   parameter int unsigned           W       = 10,
   parameter int unsigned           DATA_W  = 8,
   parameter int unsigned           ADDR_W  = 3,
   parameter logic [W-1:0]          RST     = '0,
   parameter logic [ADDR_W-1:0]     LO_ADDR = '0,
   parameter logic [ADDR_W-1:0]     HI_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load,
   output logic [W-1:0]      act
);

   logic [W-1:0] shadow;

   generate
      if (W > 2 * DATA_W) begin : g_bad_width
         $error("vbw_field_reg: field wider than two data bytes");
      end

      if (W > DATA_W) begin : g_two_byte
         localparam int unsigned HW = W - DATA_W;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shadow <= RST;
            end else if (wr) begin
               if (addr == LO_ADDR) shadow[DATA_W-1:0] <= wdata;
               if (addr == HI_ADDR) shadow[W-1:DATA_W] <= wdata[HW-1:0];
            end
         end
      end else begin : g_one_byte
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shadow <= RST;
            end else if (wr && addr == LO_ADDR) begin
               shadow <= wdata[W-1:0];
            end
         end
      end
   endgenerate

   // Active copy follows the shadow only at a field boundary
   always_ff @(posedge clk) begin
      if (!rst_n)    act <= RST;
      else if (load) act <= shadow;
   end

endmodule

// File: rtl/vbw_hwin.sv
module vbw_hwin #(
   parameter int unsigned HCNT_W    = 10,
   parameter int unsigned HS_W      = 10,
   parameter int unsigned HE_W      = 8,
   parameter int unsigned START_ORG = 32,
   parameter int unsigned END_ORG   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_rise,
   input  logic [HS_W-1:0]   hs_val,
   input  logic [HE_W-1:0]   he_val,
   output logic [HCNT_W-1:0] hcnt,
   output logic              hblank
);

   localparam int unsigned W_A   = (HCNT_W > HS_W) ? HCNT_W : HS_W;
   localparam int unsigned CMP_W = ((W_A > HE_W) ? W_A : HE_W) + 1;
   localparam logic [HCNT_W-1:0] HCNT_MAX = '1;

   logic [CMP_W-1:0] pos_start;
   logic [CMP_W-1:0] pos_end;
   logic             start_hit;
   logic             end_hit;

   generate
      if (START_ORG >= (2 ** HS_W)) begin : g_bad_start_org
         $error("vbw_hwin: start origin outside start field range");
      end
      if (END_ORG == 0) begin : g_end_direct
         assign pos_end = CMP_W'(hcnt);
      end else begin : g_end_offset
         assign pos_end = CMP_W'(hcnt) + CMP_W'(END_ORG);
      end
   endgenerate

   assign pos_start = CMP_W'(hcnt) + CMP_W'(START_ORG);
   assign start_hit = (pos_start == CMP_W'(hs_val));
   assign end_hit   = (pos_end == CMP_W'(he_val));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt   <= '0;
         hblank <= 1'b0;
      end else begin
         if (hs_rise)               hcnt <= '0;
         else if (hcnt != HCNT_MAX) hcnt <= hcnt + 1'b1;

         if (end_hit)        hblank <= 1'b0;
         else if (start_hit) hblank <= 1'b1;
      end
   end

endmodule

// File: rtl/vbw_vwin.sv
module vbw_vwin #(
   parameter int unsigned LINE_W   = 10,
   parameter int unsigned VP_W     = 9,
   parameter int unsigned NTSC_OFS = 262,
   parameter int unsigned PAL_OFS  = 313
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_rise,
   input  logic              vs_rise,
   input  logic              field_odd_i,
   input  logic              pal_i,
   input  logic [VP_W-1:0]   vs_val,
   input  logic [VP_W-1:0]   ve_val,
   output logic [LINE_W-1:0] vcnt,
   output logic [LINE_W-1:0] vs_eff,
   output logic [LINE_W-1:0] ve_eff,
   output logic              vblank
);

   localparam int unsigned BIG_OFS = (PAL_OFS > NTSC_OFS) ? PAL_OFS : NTSC_OFS;
   localparam logic [LINE_W-1:0] LINE_MAX = '1;

   logic              field_odd_q;
   logic              pal_q;
   logic [LINE_W-1:0] ofs;

   generate
      if ((2 ** VP_W) - 1 + BIG_OFS >= (2 ** LINE_W)) begin : g_bad_line_w
         $error("vbw_vwin: line counter too narrow for shifted window");
      end
      if (PAL_OFS == NTSC_OFS) begin : g_one_ofs
         always_comb ofs = field_odd_q ? '0 : LINE_W'(NTSC_OFS);
      end else begin : g_two_ofs
         always_comb ofs = field_odd_q ? '0 :
                           (pal_q ? LINE_W'(PAL_OFS) : LINE_W'(NTSC_OFS));
      end
   endgenerate

   assign vs_eff = LINE_W'(vs_val) + ofs;
   assign ve_eff = LINE_W'(ve_val) + ofs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_odd_q <= 1'b1;
         pal_q       <= 1'b0;
         vcnt        <= '0;
         vblank      <= 1'b0;
      end else begin
         if (vs_rise) begin
            field_odd_q <= field_odd_i;
            pal_q       <= pal_i;
         end

         if (vs_rise && field_odd_i)           vcnt <= '0;
         else if (hs_rise && vcnt != LINE_MAX) vcnt <= vcnt + 1'b1;

         if (vcnt == ve_eff)      vblank <= 1'b0;
         else if (vcnt == vs_eff) vblank <= 1'b1;
      end
   end

endmodule

// File: rtl/vbw_blank_gen.sv
module vbw_blank_gen
   import vbw_pkg::*;
#(
   parameter int unsigned HCNT_W   = 10,
   parameter int unsigned LINE_W   = 10,
   parameter int unsigned HS_W     = 10,
   parameter int unsigned HE_W     = 8,
   parameter int unsigned VP_W     = 9,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned HS_ORG   = 32,
   parameter int unsigned HE_ORG   = 0,
   parameter int unsigned NTSC_OFS = 262,
   parameter int unsigned PAL_OFS  = 313,
   parameter logic [HS_W-1:0] HS_RST = 10'h37A,
   parameter logic [HE_W-1:0] HE_RST = 8'h80,
   parameter logic [VP_W-1:0] VS_RST = 9'd256,
   parameter logic [VP_W-1:0] VE_RST = 9'd20,
   parameter bit              OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_i,
   input  logic              vsync_i,
   input  logic              field_odd_i,
   input  logic              pal_mode_i,
   input  logic              blank_out_en_i,
   input  logic              cfg_wr_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic              blank_o,
   output logic              pix_accept_o
);

   generate
      if (ADDR_W != VBW_ADDR_W) begin : g_bad_addr_w
         $error("vbw_blank_gen: address width does not match register codes");
      end
   endgenerate

   logic              hsync_q;
   logic              vsync_q;
   logic              hs_rise;
   logic              vs_rise;
   logic [HS_W-1:0]   hs_act;
   logic [HE_W-1:0]   he_act;
   logic [VP_W-1:0]   vs_act;
   logic [VP_W-1:0]   ve_act;
   logic [HCNT_W-1:0] hcnt;
   logic [LINE_W-1:0] vcnt;
   logic [LINE_W-1:0] vs_eff;
   logic [LINE_W-1:0] ve_eff;
   logic              hblank;
   logic              vblank;
   logic              blank_raw;

   // Sync leading-edge detection
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hsync_q <= 1'b0;
         vsync_q <= 1'b0;
      end else begin
         hsync_q <= hsync_i;
         vsync_q <= vsync_i;
      end
   end

   assign hs_rise = hsync_i & ~hsync_q;
   assign vs_rise = vsync_i & ~vsync_q;

   // Window edge registers, shadowed until the next field boundary
   vbw_field_reg #(
      .W(HS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST(HS_RST),
      .LO_ADDR(ADDR_W'(REG_HS_LO)), .HI_ADDR(ADDR_W'(REG_HS_HI))
   ) u_hs_reg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .addr(cfg_addr_i),
      .wdata(cfg_wdata_i), .load(vs_rise), .act(hs_act)
   );

   vbw_field_reg #(
      .W(HE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST(HE_RST),
      .LO_ADDR(ADDR_W'(REG_HE)), .HI_ADDR(ADDR_W'(REG_HE))
   ) u_he_reg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .addr(cfg_addr_i),
      .wdata(cfg_wdata_i), .load(vs_rise), .act(he_act)
   );

   vbw_field_reg #(
      .W(VP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST(VS_RST),
      .LO_ADDR(ADDR_W'(REG_VS_LO)), .HI_ADDR(ADDR_W'(REG_VS_HI))
   ) u_vs_reg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .addr(cfg_addr_i),
      .wdata(cfg_wdata_i), .load(vs_rise), .act(vs_act)
   );

   vbw_field_reg #(
      .W(VP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST(VE_RST),
      .LO_ADDR(ADDR_W'(REG_VE_LO)), .HI_ADDR(ADDR_W'(REG_VE_HI))
   ) u_ve_reg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .addr(cfg_addr_i),
      .wdata(cfg_wdata_i), .load(vs_rise), .act(ve_act)
   );

   vbw_hwin #(
      .HCNT_W(HCNT_W), .HS_W(HS_W), .HE_W(HE_W),
      .START_ORG(HS_ORG), .END_ORG(HE_ORG)
   ) u_hwin (
      .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise),
      .hs_val(hs_act), .he_val(he_act), .hcnt(hcnt), .hblank(hblank)
   );

   vbw_vwin #(
      .LINE_W(LINE_W), .VP_W(VP_W), .NTSC_OFS(NTSC_OFS), .PAL_OFS(PAL_OFS)
   ) u_vwin (
      .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
      .field_odd_i(field_odd_i), .pal_i(pal_mode_i),
      .vs_val(vs_act), .ve_val(ve_act), .vcnt(vcnt),
      .vs_eff(vs_eff), .ve_eff(ve_eff), .vblank(vblank)
   );

   assign blank_raw = blank_out_en_i & (hblank | vblank);

   generate
      if (OUT_REG) begin : g_out_reg
         logic blank_q;
         always_ff @(posedge clk) begin
            if (!rst_n) blank_q <= 1'b0;
            else        blank_q <= blank_raw;
         end
         assign blank_o = blank_q;
      end else begin : g_out_comb
         assign blank_o = blank_raw;
      end
   endgenerate

   assign pix_accept_o = ~blank_o;

endmodule

// File: rtl/vbw_blank_chk.sv
module vbw_blank_chk #(
   parameter int unsigned HCNT_W    = 10,
   parameter int unsigned LINE_W    = 10,
   parameter int unsigned HS_W      = 10,
   parameter int unsigned HE_W      = 8,
   parameter int unsigned VP_W      = 9,
   parameter int unsigned START_ORG = 32,
   parameter int unsigned END_ORG   = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vsync_i,
   input logic              field_odd_i,
   input logic [HCNT_W-1:0] hcnt,
   input logic              hblank,
   input logic [LINE_W-1:0] vcnt,
   input logic              vblank,
   input logic [LINE_W-1:0] vs_eff,
   input logic [LINE_W-1:0] ve_eff,
   input logic [HS_W-1:0]   hs_act,
   input logic [HE_W-1:0]   he_act,
   input logic [VP_W-1:0]   vs_act,
   input logic [VP_W-1:0]   ve_act
);

   logic vs_prev;
   logic vs_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) vs_prev <= 1'b0;
      else        vs_prev <= vsync_i;
   end

   assign vs_edge = vsync_i & ~vs_prev;

   // R2: horizontal window opens only after the start position was reached
   p_hstart_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hblank) |-> $past(int'(hcnt) + int'(START_ORG) == int'(hs_act)));

   // R3: horizontal window closes only after the end position was reached
   p_hend_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hblank) |-> $past(int'(hcnt) + int'(END_ORG) == int'(he_act)));

   // R5: odd-field vertical sync edge restarts the line count
   p_line_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_edge && field_odd_i) |=> (vcnt == '0));

   // R5: vertical window closes only on its shifted end line
   p_vend_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vblank) |-> $past(vcnt == ve_eff));

   // R6: vertical window opens only on its shifted start line
   p_vstart_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vblank) |-> $past(vcnt == vs_eff));

   // R8: active window edges change only right after a vertical sync edge
   p_cfg_field_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(hs_act) || !$stable(he_act) || !$stable(vs_act) || !$stable(ve_act))
      |-> $past(vs_edge));

endmodule

bind vbw_blank_gen vbw_blank_chk #(
   .HCNT_W(HCNT_W), .LINE_W(LINE_W), .HS_W(HS_W), .HE_W(HE_W), .VP_W(VP_W),
   .START_ORG(HS_ORG), .END_ORG(HE_ORG)
) chk_i (
   .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .field_odd_i(field_odd_i),
   .hcnt(hcnt), .hblank(hblank), .vcnt(vcnt), .vblank(vblank),
   .vs_eff(vs_eff), .ve_eff(ve_eff), .hs_act(hs_act), .he_act(he_act),
   .vs_act(vs_act), .ve_act(ve_act)
);

// File: tb/vbw_blank_gen_tb_top.sv
module vbw_blank_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam int VLEN       = 48;

   // Pixel count (bits 8:1) and expected blank_o (bit 0) on a steady line
   // with start 62 (count 30 + 0x20) and end 10
   localparam logic [8:0] H_TAB [8] = '{
      {8'd0,  1'b1}, {8'd5,  1'b1}, {8'd10, 1'b1}, {8'd11, 1'b0},
      {8'd20, 1'b0}, {8'd30, 1'b0}, {8'd31, 1'b1}, {8'd47, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       hsync_i, vsync_i, field_odd_i, pal_mode_i, blank_out_en_i;
   logic       cfg_wr_i;
   logic [2:0] cfg_addr_i;
   logic [7:0] cfg_wdata_i;
   logic       blank_o, pix_accept_o;

   int  checks   = 0;
   int  failures = 0;
   bit  done     = 1'b0;
   logic log_b [1024];
   logic log_a [1024];

   always #(CLK_PERIOD / 2) clk = ~clk;

   vbw_blank_gen dut_i (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
      .field_odd_i(field_odd_i), .pal_mode_i(pal_mode_i),
      .blank_out_en_i(blank_out_en_i), .cfg_wr_i(cfg_wr_i),
      .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
      .blank_o(blank_o), .pix_accept_o(pix_accept_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_pix(input int k, input bit exp, input string req);
      chk(log_b[k] === exp, req, int'(log_b[k]), int'(exp));
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_i    = 1'b1;
      cfg_addr_i  = a;
      cfg_wdata_i = d;
      @(negedge clk);
      cfg_wr_i    = 1'b0;
   endtask

   // Drives one line; log index k holds the outputs seen at pixel count k
   task automatic run_line(input int len);
      for (int c = 0; c < len; c++) begin
         @(negedge clk);
         if (c > 0) begin
            log_b[c-1] = blank_o;
            log_a[c-1] = pix_accept_o;
         end
         hsync_i = (c < 4);
      end
      @(negedge clk);
      log_b[len-1] = blank_o;
      log_a[len-1] = pix_accept_o;
   endtask

   task automatic run_lines(input int n, input int len);
      for (int i = 0; i < n; i++) run_line(len);
   endtask

   task automatic vsync_pulse(input bit odd, input bit pal);
      @(negedge clk);
      vsync_i     = 1'b1;
      field_odd_i = odd;
      pal_mode_i  = pal;
      repeat (2) @(negedge clk);
      vsync_i = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0; field_odd_i = 1'b1;
      pal_mode_i = 1'b0; blank_out_en_i = 1'b0; cfg_wr_i = 1'b0;
      cfg_addr_i = '0; cfg_wdata_i = '0;
      repeat (4) @(negedge clk);
      // R1: outputs during and after reset
      chk(blank_o === 1'b0, "R1 blank in reset", int'(blank_o), 0);
      chk(pix_accept_o === 1'b1, "R1 accept in reset", int'(pix_accept_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(blank_o === 1'b0, "R1 blank after reset", int'(blank_o), 0);
      chk(pix_accept_o === 1'b1, "R1 accept after reset", int'(pix_accept_o), 1);

      // R1/R2: default start 0x37A opens at count 0x37A-0x20+1 = 859
      blank_out_en_i = 1'b1;
      run_line(900);
      chk_pix(858, 1'b0, "R2 default start before");
      chk_pix(859, 1'b1, "R2 default start edge");
      chk(log_a[859] === 1'b0, "R10 accept low while blank", int'(log_a[859]), 0);
      // R1/R3: default end 0x80 closes after count 128, across the wrap
      run_line(900);
      chk_pix(0, 1'b1, "R3 window across line wrap");
      chk_pix(128, 1'b1, "R3 default end still on");
      chk_pix(129, 1'b0, "R3 default end off");

      // R9: disabled output never blanks
      blank_out_en_i = 1'b0;
      run_line(900);
      begin
         int ones = 0;
         int acc0 = 0;
         for (int k = 0; k < 900; k++) begin
            if (log_b[k] !== 1'b0) ones++;
            if (log_a[k] !== 1'b1) acc0++;
         end
         chk(ones == 0, "R9 blank stays low when disabled", ones, 0);
         chk(acc0 == 0, "R9 accept stays high when disabled", acc0, 0);
      end
      blank_out_en_i = 1'b1;

      // R4: start 62, end 10, vertical start 3, end 6
      wr_reg(3'd0, 8'd62); wr_reg(3'd1, 8'd0); wr_reg(3'd2, 8'd10);
      wr_reg(3'd3, 8'd3);  wr_reg(3'd4, 8'd0); wr_reg(3'd5, 8'd6);
      wr_reg(3'd6, 8'd0);
      // R8: old end 128 still active, window stays on through count 20
      run_line(60);
      chk_pix(20, 1'b1, "R8 write not yet applied");

      vsync_pulse(1'b1, 1'b0);
      run_line(VLEN);            // line 1
      run_line(VLEN);            // line 2
      for (int i = 0; i < 8; i++) begin
         int k;
         k = int'(H_TAB[i][8:1]);
         chk_pix(k, H_TAB[i][0], "R2 R3 R8 table vector");
         chk(log_a[k] === ~H_TAB[i][0], "R10 accept inverse", int'(log_a[k]), int'(~H_TAB[i][0]));
      end

      // R5: odd field vertical window, lines 3..5
      run_line(VLEN); chk_pix(20, 1'b1, "R5 odd start line 3");
      run_line(VLEN);
      run_line(VLEN); chk_pix(20, 1'b1, "R5 odd last line 5");
      run_line(VLEN); chk_pix(20, 1'b0, "R5 odd end line 6");
      run_lines(256, VLEN);      // lines 7..262

      // R6: even field, 525-line offset, lines 265..267
      vsync_pulse(1'b0, 1'b0);
      run_line(VLEN);
      run_line(VLEN); chk_pix(20, 1'b0, "R6 even line 264");
      run_line(VLEN); chk_pix(20, 1'b1, "R6 even line 265");
      run_line(VLEN);
      run_line(VLEN); chk_pix(20, 1'b1, "R6 even line 267");
      run_line(VLEN); chk_pix(20, 1'b0, "R6 even line 268");

      // R7: 625-line timing, odd field unshifted, even field lines 316..318
      vsync_pulse(1'b1, 1'b1);
      run_lines(2, VLEN);
      run_line(VLEN); chk_pix(20, 1'b1, "R7 odd line 3 unshifted");
      run_lines(309, VLEN);      // lines 4..312
      vsync_pulse(1'b0, 1'b1);
      run_lines(2, VLEN);        // lines 313, 314
      run_line(VLEN); chk_pix(20, 1'b0, "R7 even line 315");
      run_line(VLEN); chk_pix(20, 1'b1, "R7 even line 316");
      run_line(VLEN);
      run_line(VLEN); chk_pix(20, 1'b1, "R7 even line 318");
      run_line(VLEN); chk_pix(20, 1'b0, "R7 even line 319");

      // R4: 10-bit start 0x124 = 292 via high byte, opens at count 261
      wr_reg(3'd0, 8'h24);
      wr_reg(3'd1, 8'h01);
      vsync_pulse(1'b1, 1'b0);
      run_line(300);
      chk_pix(260, 1'b0, "R4 high start bits before");
      chk_pix(261, 1'b1, "R4 high start bits edge");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule